// File: doc/BRIEF.md
# Page Write Buffer and Self-Timed Commit Engine

This block sits behind the serial front end of a small nonvolatile memory. An array write or a status write begins with a start pulse. The data bytes of that transaction are gathered into a page buffer, and the block tracks which slots have been filled. It also counts the data bits it has received, so it can tell whether the chip-select rise that ends the transaction falls on a byte boundary.

If the rise is on a boundary, the transaction holds at least one byte and the protection logic grants permission, the block runs a write cycle of fixed length. The busy flag is high for the whole cycle. When the cycle ends, the filled slots are written into an internal byte array, or the buffered byte is handed to the status register. In the same cycle a one-cycle pulse clears the write-enable latch.

Any other rise throws the transaction away. While busy, the block accepts no new transaction, no byte and no chip-select rise. The array can be read at any time through a combinational read port.

Top module: `page_write_engine`

## Requirements
- R1: A pulse on `arr_start_i` takes the page from the upper bits of `start_addr_i` and the first buffer slot from its low log2(PAGE_BYTES) bits. Each `byte_valid_i` then stores `byte_data_i` in the current slot and moves to the next slot.
- R2: Once the last slot of the page has been filled, the next byte goes to slot 0 of the same page. A later byte replaces an earlier buffered byte in the same slot.
- R3: A `cs_rise_i` during loading starts a write cycle only if two things hold: the number of `bit_tick_i` pulses since the start is a multiple of 8, and at least one byte has been loaded. Otherwise the transaction is dropped, `busy_o` stays 0 and the array is unchanged.
- R4: A `cs_rise_i` that meets R3 while `permit_i` is 0 drops the transaction with no busy interval and no array change.
- R5: `busy_o` goes to 1 in the cycle after a qualifying `cs_rise_i` and stays at 1 for exactly WC_CYCLES cycles.
- R6: At the clock edge that ends the busy interval, each slot loaded in the transaction is written to page address + slot. Every other array location keeps its contents, and the array changes at no other time.
- R7: `wel_clr_o` is 1 for exactly one cycle per committed write: the last cycle in which `busy_o` is 1. It never pulses for a dropped transaction.
- R8: While `busy_o` is 1, `arr_start_i`, `sr_start_i`, `byte_valid_i`, `bit_tick_i` and `cs_rise_i` have no effect. The busy length is unchanged, the array is unchanged, and no second busy interval follows.
- R9: A pulse on `sr_start_i` opens a status write that holds a single slot, so each byte replaces the previous one. On commit, `sr_commit_o` is 1 in the last busy cycle with `sr_data_o` equal to the last byte loaded, and the array is unchanged.
- R10: After reset, `busy_o`, `wel_clr_o` and `sr_commit_o` are 0 and every array location reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arr_start_i | input | 1 | Opens an array write transaction |
| sr_start_i | input | 1 | Opens a status write transaction |
| start_addr_i | input | ADDR_W | Start address of an array write |
| bit_tick_i | input | 1 | One pulse per data bit received |
| byte_valid_i | input | 1 | A complete data byte is present |
| byte_data_i | input | 8 | Data byte |
| cs_rise_i | input | 1 | Chip select has gone inactive |
| permit_i | input | 1 | Protection logic allows this write |
| rd_addr_i | input | ADDR_W | Array read address |
| rd_data_o | output | 8 | Array read data |
| busy_o | output | 1 | Write cycle in progress |
| wel_clr_o | output | 1 | Clears the write-enable latch |
| sr_commit_o | output | 1 | Status byte is valid for commit |
| sr_data_o | output | 8 | Status byte to commit |

## Verification
Two events can land in the same cycle: the end of the write cycle, which writes the array and pulses `wel_clr_o`, and stimulus arriving while the block is still busy. The bench provokes this by sending a start, a full data byte, a chip-select rise and a status start during a busy interval. It then judges three things: the busy count must stay exactly WC_CYCLES, the array must match a model built only from the first transaction, and no second busy interval may follow. A bit-aligned sweep over every start slot and over byte counts that cross the page end checks the wrap and the partial-page write together.

// File: rtl/pwe_pkg.sv
package pwe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_LOAD_ARR = 2'd1,
    ST_LOAD_SR  = 2'd2,
    ST_BUSY     = 2'd3
  } pwe_state_e;

  typedef enum logic {
    KIND_ARR = 1'b0,
    KIND_SR  = 1'b1
  } pwe_kind_e;
endpackage

// File: rtl/pwe_page_buf.sv
module pwe_page_buf #(
  parameter int PAGE_BYTES = 32,
  localparam int OFF_W = $clog2(PAGE_BYTES)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            clear_i,
  input  logic [OFF_W-1:0]                start_off_i,
  input  logic                            load_i,
  input  logic                            incr_i,
  input  logic [7:0]                      data_i,
  output logic [PAGE_BYTES-1:0][7:0]      buf_o,
  output logic [PAGE_BYTES-1:0]           mask_o,
  output logic                            any_o
);
  logic [OFF_W-1:0]           off_q;
  logic [PAGE_BYTES-1:0][7:0] buf_q;
  logic [PAGE_BYTES-1:0]      mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q  <= '0;
      mask_q <= '0;
    end else if (clear_i) begin
      off_q  <= start_off_i;
      mask_q <= '0;
    end else if (load_i) begin
      mask_q[off_q] <= 1'b1;
      if (incr_i) off_q <= off_q + 1'b1;  // power-of-two page wraps in place
    end
  end

  for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) buf_q[s] <= 8'h00;
      else if (load_i && !clear_i && off_q == OFF_W'(s)) buf_q[s] <= data_i;
    end
  end

  assign buf_o  = buf_q;
  assign mask_o = mask_q;
  assign any_o  = |mask_q;

  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !any_o); // R1
  AST_LOAD_MARKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clear_i) |=> any_o); // R2
endmodule

// File: rtl/pwe_cycle_timer.sv
module pwe_cycle_timer #(
  parameter int WC_CYCLES = 1000,
  localparam int CNT_W = $clog2(WC_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(WC_CYCLES - 1);
      end
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  AST_NO_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q); // R8
  AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_o) |=> busy_q); // R5
  AST_DONE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_q); // R5
endmodule

// File: rtl/pwe_array.sv
module pwe_array #(
  parameter int ADDR_W     = 8,
  parameter int PAGE_BYTES = 32,
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int PAGE_W = ADDR_W - OFF_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       commit_i,
  input  logic [PAGE_W-1:0]          page_i,
  input  logic [PAGE_BYTES-1:0][7:0] buf_i,
  input  logic [PAGE_BYTES-1:0]      mask_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  output logic [7:0]                 rd_data_o
);
  logic [DEPTH-1:0][7:0] mem_q;

  for (genvar a = 0; a < DEPTH; a++) begin : g_row
    localparam int SLOT = a % PAGE_BYTES;
    localparam int PG   = a / PAGE_BYTES;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[a] <= 8'hFF;
      else if (commit_i && page_i == PAGE_W'(PG) && mask_i[SLOT]) mem_q[a] <= buf_i[SLOT];
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  AST_ARRAY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(mem_q)); // R6
endmodule

// File: rtl/page_write_engine.sv
module page_write_engine
  import pwe_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int PAGE_BYTES = 32,
  parameter int WC_CYCLES  = 1000,
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int PAGE_W = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arr_start_i,
  input  logic              sr_start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              bit_tick_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_data_i,
  input  logic              cs_rise_i,
  input  logic              permit_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              busy_o,
  output logic              wel_clr_o,
  output logic              sr_commit_o,
  output logic [7:0]        sr_data_o
);
  pwe_state_e  state_q, state_d;
  pwe_kind_e   kind_q;
  logic [PAGE_W-1:0] page_q;
  logic [2:0]  bit_cnt_q;

  logic loading, accept_start, load, qualify, ending;
  logic timer_busy, timer_done, any_loaded;
  logic [OFF_W-1:0] start_off;
  logic [PAGE_BYTES-1:0][7:0] page_buf;
  logic [PAGE_BYTES-1:0]      page_mask;

  assign loading      = (state_q == ST_LOAD_ARR) || (state_q == ST_LOAD_SR);
  assign accept_start = (state_q != ST_BUSY) && (arr_start_i || sr_start_i);
  assign ending       = loading && cs_rise_i;
  assign load         = loading && byte_valid_i && !accept_start && !cs_rise_i;
  assign qualify      = ending && (bit_cnt_q == 3'd0) && any_loaded && permit_i;
  assign start_off    = arr_start_i ? start_addr_i[OFF_W-1:0] : '0;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (arr_start_i)     state_d = ST_LOAD_ARR;
        else if (sr_start_i) state_d = ST_LOAD_SR;
      end
      ST_LOAD_ARR, ST_LOAD_SR: begin
        if (cs_rise_i)        state_d = qualify ? ST_BUSY : ST_IDLE;
        else if (arr_start_i) state_d = ST_LOAD_ARR;
        else if (sr_start_i)  state_d = ST_LOAD_SR;
      end
      ST_BUSY: if (timer_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      kind_q    <= KIND_ARR;
      page_q    <= '0;
      bit_cnt_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept_start && !ending) begin
        kind_q    <= arr_start_i ? KIND_ARR : KIND_SR;
        bit_cnt_q <= '0;
        if (arr_start_i) page_q <= start_addr_i[ADDR_W-1:OFF_W];
      end else if (loading && bit_tick_i) begin
        bit_cnt_q <= bit_cnt_q + 3'd1;
      end
    end
  end

  pwe_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (accept_start && !ending),
    .start_off_i (start_off),
    .load_i      (load),
    .incr_i      (kind_q == KIND_ARR),
    .data_i      (byte_data_i),
    .buf_o       (page_buf),
    .mask_o      (page_mask),
    .any_o       (any_loaded)
  );

  pwe_cycle_timer #(.WC_CYCLES(WC_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (qualify),
    .busy_o  (timer_busy),
    .done_o  (timer_done)
  );

  pwe_array #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .commit_i  (timer_done && kind_q == KIND_ARR),
    .page_i    (page_q),
    .buf_i     (page_buf),
    .mask_i    (page_mask),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  assign busy_o      = timer_busy;
  assign wel_clr_o   = timer_done;
  assign sr_commit_o = timer_done && kind_q == KIND_SR;
  assign sr_data_o   = page_buf[0];

  AST_BUSY_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(bit_cnt_q) == 3'd0 && $past(permit_i))); // R3
  AST_STATE_TRACKS_TIMER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> state_q == ST_BUSY); // R8
  AST_WEL_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wel_clr_o |=> !busy_o); // R7
  AST_SR_WITH_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_commit_o |-> (wel_clr_o && busy_o)); // R9
endmodule

// File: tb/page_write_engine_tb_top.sv
module page_write_engine_tb_top;
  localparam int ADDR_W = 7;
  localparam int PB     = 32;
  localparam int WC     = 20;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arr_start = 0, sr_start = 0, bit_tick = 0, byte_valid = 0, cs_rise = 0, permit = 1;
  logic [ADDR_W-1:0] start_addr = '0, rd_addr = '0;
  logic [7:0] byte_data = '0, rd_data, sr_data;
  logic busy, wel_clr, sr_commit;

  int tests = 0, fails = 0;
  bit finished = 0;
  logic [7:0] exp_mem [DEPTH];

  always #5 clk = ~clk;

  page_write_engine #(.ADDR_W(ADDR_W), .PAGE_BYTES(PB), .WC_CYCLES(WC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .arr_start_i(arr_start), .sr_start_i(sr_start),
    .start_addr_i(start_addr), .bit_tick_i(bit_tick), .byte_valid_i(byte_valid),
    .byte_data_i(byte_data), .cs_rise_i(cs_rise), .permit_i(permit),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .busy_o(busy), .wel_clr_o(wel_clr),
    .sr_commit_o(sr_commit), .sr_data_o(sr_data)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_array(input string req);
    int bad = 0, first = -1, act = 0, exp = 0;
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr = a[ADDR_W-1:0];
      #1;
      if (rd_data !== exp_mem[a]) begin
        bad++;
        if (first < 0) begin first = a; act = rd_data; exp = exp_mem[a]; end
      end
    end
    chk(bad == 0, req, $sformatf("array mismatches %0d first addr %0d", bad, first), act, exp);
  endtask

  task automatic pulse_arr(input int addr);
    @(negedge clk); arr_start = 1; start_addr = addr[ADDR_W-1:0];
    @(negedge clk); arr_start = 0;
  endtask

  task automatic pulse_sr();
    @(negedge clk); sr_start = 1;
    @(negedge clk); sr_start = 0;
  endtask

  task automatic send_bits(input int n, input logic [7:0] d, input bit full);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_tick = 1; byte_valid = full && (i == n - 1); byte_data = d;
    end
    @(negedge clk); bit_tick = 0; byte_valid = 0;
  endtask

  task automatic cs_pulse(input logic p);
    @(negedge clk); cs_rise = 1; permit = p;
    @(negedge clk); cs_rise = 0; permit = 1;
  endtask

  // Called with busy already visible; returns at the first negedge with busy low.
  task automatic measure(output int cyc, output int wel_n, output int wel_at,
                         output int src_n, output int src_data);
    cyc = 0; wel_n = 0; wel_at = -1; src_n = 0; src_data = -1;
    while (busy && cyc < 1000) begin
      cyc++;
      if (wel_clr) begin wel_n++; wel_at = cyc; end
      if (sr_commit) begin src_n++; src_data = sr_data; end
      @(negedge clk);
    end
  endtask

  task automatic quiet_window(input string req, input int n);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      if (busy || wel_clr || sr_commit) seen++;
      @(negedge clk);
    end
    chk(seen == 0, req, "busy/wel/sr activity on dropped write", seen, 0);
  endtask

  initial begin : watchdog
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (finished) disable watchdog;
    end
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int cyc, wel_n, wel_at, src_n, src_data, off, page, n;
    for (int a = 0; a < DEPTH; a++) exp_mem[a] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R10 reset state
    chk(busy == 0 && wel_clr == 0 && sr_commit == 0, "R10", "outputs after reset",
        {busy, wel_clr, sr_commit}, 0);
    check_array("R10");

    // R1 R2 R5 R6 R7: sweep of start slot, byte count and page
    for (int s = 0; s < PB; s++) begin
      page = s % 4;
      n = (s % 5) * 9 + 1;
      off = s;
      pulse_arr(page * PB + s);
      for (int k = 0; k < n; k++) begin
        logic [7:0] d;
        d = 8'((s * 7 + k * 13 + page * 3 + 1) & 8'hFF);
        send_bits(8, d, 1'b1);
        exp_mem[page * PB + off] = d;
        off = (off + 1) % PB;
      end
      cs_pulse(1'b1);
      measure(cyc, wel_n, wel_at, src_n, src_data);
      chk(cyc == WC, "R5", $sformatf("busy length slot %0d", s), cyc, WC);
      chk(wel_n == 1 && wel_at == WC, "R7", "wel pulse position", wel_at, WC);
      check_array(n > PB ? "R2" : "R1_R6");
    end

    // R3: rise after a partial byte
    pulse_arr(2 * PB + 4);
    send_bits(8, 8'hA5, 1'b1);
    send_bits(3, 8'h00, 1'b0);
    cs_pulse(1'b1);
    quiet_window("R3", WC + 4);
    check_array("R3");

    // R3: rise with no byte loaded
    pulse_arr(PB + 1);
    cs_pulse(1'b1);
    quiet_window("R3", 6);

    // R4: permission denied
    pulse_arr(3 * PB + 10);
    send_bits(8, 8'h3C, 1'b1);
    cs_pulse(1'b0);
    quiet_window("R4", WC + 4);
    check_array("R4");

    // R8: stimulus during busy is ignored
    pulse_arr(PB + 3);
    send_bits(8, 8'h5A, 1'b1);
    send_bits(8, 8'hC3, 1'b1);
    exp_mem[PB + 3] = 8'h5A;
    exp_mem[PB + 4] = 8'hC3;
    cs_pulse(1'b1);
    cyc = 1;
    pulse_arr(2 * PB);        cyc += 2;
    send_bits(8, 8'h77, 1'b1); cyc += 9;
    cs_pulse(1'b1);            cyc += 2;
    pulse_sr();                cyc += 2;
    measure(wel_at, wel_n, src_data, src_n, off);
    chk(cyc + wel_at - 1 == WC, "R8", "busy length with stimulus", cyc + wel_at - 1, WC);
    chk(src_n == 0, "R8", "status commit during ignored busy", src_n, 0);
    check_array("R8");
    cs_pulse(1'b1);
    quiet_window("R8", WC + 2);

    // R9: status write, last byte wins, array untouched
    pulse_sr();
    send_bits(8, 8'h11, 1'b1);
    send_bits(8, 8'h8C, 1'b1);
    cs_pulse(1'b1);
    measure(cyc, wel_n, wel_at, src_n, src_data);
    chk(src_n == 1, "R9", "sr commit pulses", src_n, 1);
    chk(src_data == 8'h8C, "R9", "sr data", src_data, 8'h8C);
    chk(cyc == WC && wel_at == WC, "R9", "status busy length", cyc, WC);
    check_array("R9");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule